// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two data ports, A and B, over a configurable width (18 bits by default). Two paths run in opposite directions, A toward B and B toward A. Each path has its own storage node that works as a transparent latch or as an edge-captured register. Each path also has its own four controls: an active-low drive enable, a pass (latch enable) level, a capture strobe and an active-low strobe enable. When the pass level is high, the stored word is bypassed and the path is transparent. When it is low, the path either holds or takes a new word on a strobe rise.

Each port has a separate input, output and output-enable per bit instead of a true inout. The integrator combines them into a tri-state pad or a shared-bus mux. The block runs on one system clock. The capture strobe of each path is sampled on that clock, and a rise is a sample of 1 that follows a sample of 0. The strobe rate must therefore stay below half the system clock rate. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `tcvr_bidir`

## Requirements
- R1: While reset is asserted, and until the release has passed two system clock edges, `a_oe_o` and `b_oe_o` are low whatever the drive controls are. Both stored words reset to zero.
- R2: While a path's pass input is high, its output equals its input in the same cycle, with no register delay.
- R3: While pass is high, the stored word takes the input at every clock edge. After pass falls, the output holds the input sampled at the last clock edge at which pass was high.
- R4: With pass low and strobe enable low, a strobe rise (sampled 1 at this edge, 0 at the previous edge) stores the input sampled at that edge. The output shows it right after that edge.
- R5: With pass low, a strobe held steady high or steady low leaves the output unchanged while the input moves.
- R6: With strobe enable high, strobe rises are ignored and the output keeps its level.
- R7: Strobe enable and strobe have no effect while pass is high. The output keeps following the input.
- R8: Out of reset, a path's output enable is high exactly when its drive enable input is low. `b_oe_o` belongs to the A-to-B path and `a_oe_o` to the B-to-A path. Enabling both at once is a usage error and is flagged by an assertion.
- R9: The two paths are independent. Activity on one path's input or controls leaves the other path's output and output enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in_i | input | WIDTH | Data arriving on port A (A-to-B path input) |
| a_out_o | output | WIDTH | Data to drive on port A (B-to-A path output) |
| a_oe_o | output | 1 | Port A driver enable; low means high-impedance |
| b_in_i | input | WIDTH | Data arriving on port B (B-to-A path input) |
| b_out_o | output | WIDTH | Data to drive on port B (A-to-B path output) |
| b_oe_o | output | 1 | Port B driver enable; low means high-impedance |
| ab_drive_n_i | input | 1 | A-to-B drive enable, active low |
| ab_pass_i | input | 1 | A-to-B transparent (latch enable) level |
| ab_strobe_i | input | 1 | A-to-B capture strobe; rising sample captures |
| ab_strobe_en_n_i | input | 1 | A-to-B strobe enable, active low |
| ba_drive_n_i | input | 1 | B-to-A drive enable, active low |
| ba_pass_i | input | 1 | B-to-A transparent (latch enable) level |
| ba_strobe_i | input | 1 | B-to-A capture strobe; rising sample captures |
| ba_strobe_en_n_i | input | 1 | B-to-A strobe enable, active low |

## Verification
A wrong stored word stays hidden while pass is high. It appears on the port output in the first cycle after pass falls, or right after the edge that should have captured a strobe rise. For that reason the stimulus spends most cycles with pass low. A broken edge detector shows one of two ways. Either it captures on a steady-high strobe, so the output changes one cycle after a data change with no rise. Or it misses a rise, so the old word stays after the capture edge. A swap between the paths shows at once, because both outputs and both enables are compared every cycle against an independent model.

// File: rtl/tcvr_pkg.sv
package tcvr_pkg;

  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;

  typedef struct packed {
    logic drive_n;
    logic pass;
    logic strobe;
    logic strobe_en_n;
  } tcvr_ctl_t;

endpackage

// File: rtl/tcvr_rst_sync.sv
module tcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok_n = sync_q[STAGES-1];

endmodule

// File: rtl/tcvr_lane.sv
module tcvr_lane
  import tcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_ok_n,
  input  logic [WIDTH-1:0] din,
  input  tcvr_ctl_t        ctl,
  output logic [WIDTH-1:0] dout,
  output logic             oe
);

  logic             pass_w;
  logic             strobe_w;
  logic             en_n_w;
  logic             strobe_q;
  logic             strobe_d;
  logic             rise;
  logic             fire;
  logic             hold_ld;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;
  logic [1:0]       arm_q;

  assign pass_w   = ctl.pass;
  assign strobe_w = ctl.strobe;
  assign en_n_w   = ctl.strobe_en_n;

  // edge detect on the sampled strobe; transparency outranks clocked capture
  assign rise    = strobe_w & ~strobe_q;
  assign fire    = ~pass_w & ~en_n_w & rise;
  assign hold_ld = pass_w | fire;

  always_comb begin
    strobe_d = strobe_w;
    hold_d   = hold_q;
    if (hold_ld) begin
      hold_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      strobe_q <= 1'b1;
      hold_q   <= '0;
    end else begin
      strobe_q <= strobe_d;
      if (hold_ld) begin
        hold_q <= hold_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      arm_q <= 2'b00;
    end else begin
      arm_q <= {arm_q[0], 1'b1};
    end
  end

  assign dout = pass_w ? din : hold_q;
  assign oe   = rst_ok_n & ~drive_n_sel();

  function automatic logic drive_n_sel();
    return ctl.drive_n;
  endfunction

  AST_PASS_TRACKS: assert property (@(posedge clk) disable iff (!arm_q[1])
    $past(pass_w) |-> (hold_q == $past(din))); // R3

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!arm_q[1])
    ($past(!pass_w && !en_n_w && strobe_w) && !$past(strobe_w, 2)) |-> (hold_q == $past(din))); // R4

  AST_STEADY_HOLD: assert property (@(posedge clk) disable iff (!arm_q[1])
    ($past(!pass_w) && ($past(strobe_w) == $past(strobe_w, 2))) |-> $stable(hold_q)); // R5

  AST_GATED_EDGE: assert property (@(posedge clk) disable iff (!arm_q[1])
    ($past(!pass_w) && $past(en_n_w)) |-> $stable(hold_q)); // R6

endmodule

// File: rtl/tcvr_bidir.sv
module tcvr_bidir
  import tcvr_pkg::*;
#(
  parameter int WIDTH      = 18,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] b_out_o,
  output logic             b_oe_o,
  input  logic             ab_drive_n_i,
  input  logic             ab_pass_i,
  input  logic             ab_strobe_i,
  input  logic             ab_strobe_en_n_i,
  input  logic             ba_drive_n_i,
  input  logic             ba_pass_i,
  input  logic             ba_strobe_i,
  input  logic             ba_strobe_en_n_i
);

  logic             rst_ok_n;
  logic [WIDTH-1:0] lane_in  [NUM_DIR];
  logic [WIDTH-1:0] lane_out [NUM_DIR];
  logic             lane_oe  [NUM_DIR];
  tcvr_ctl_t        lane_ctl [NUM_DIR];

  tcvr_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  assign lane_in[DIR_AB]  = a_in_i;
  assign lane_in[DIR_BA]  = b_in_i;
  assign lane_ctl[DIR_AB] = '{drive_n: ab_drive_n_i, pass: ab_pass_i,
                              strobe: ab_strobe_i, strobe_en_n: ab_strobe_en_n_i};
  assign lane_ctl[DIR_BA] = '{drive_n: ba_drive_n_i, pass: ba_pass_i,
                              strobe: ba_strobe_i, strobe_en_n: ba_strobe_en_n_i};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    tcvr_lane #(
      .WIDTH (WIDTH)
    ) u_lane (
      .clk      (clk),
      .rst_ok_n (rst_ok_n),
      .din      (lane_in[d]),
      .ctl      (lane_ctl[d]),
      .dout     (lane_out[d]),
      .oe       (lane_oe[d])
    );
  end

  // A-to-B path drives port B, B-to-A path drives port A
  assign b_out_o = lane_out[DIR_AB];
  assign b_oe_o  = lane_oe[DIR_AB];
  assign a_out_o = lane_out[DIR_BA];
  assign a_oe_o  = lane_oe[DIR_BA];

  AST_DARK_IN_RESET: assert property (@(posedge clk)
    !rst_ok_n |-> (!a_oe_o && !b_oe_o)); // R1

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(a_oe_o && b_oe_o)); // R8

endmodule

// File: tb/tcvr_bidir_bench.sv
`timescale 1ns/1ps
module tcvr_bidir_bench;

  localparam int W = 18;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] din  [2];
  logic         drv_n[2];
  logic         pass [2];
  logic         stb  [2];
  logic         en_n [2];
  wire  [W-1:0] a_out, b_out;
  wire          a_oe, b_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [W-1:0] m_hold[2];
  logic         m_prev[2];
  string        m_tag [2];

  tcvr_bidir #(.WIDTH(W)) u_tcvr_bidir (
    .clk              (clk),
    .rst_n            (rst_n),
    .a_in_i           (din[0]),
    .a_out_o          (a_out),
    .a_oe_o           (a_oe),
    .b_in_i           (din[1]),
    .b_out_o          (b_out),
    .b_oe_o           (b_oe),
    .ab_drive_n_i     (drv_n[0]),
    .ab_pass_i        (pass[0]),
    .ab_strobe_i      (stb[0]),
    .ab_strobe_en_n_i (en_n[0]),
    .ba_drive_n_i     (drv_n[1]),
    .ba_pass_i        (pass[1]),
    .ba_strobe_i      (stb[1]),
    .ba_strobe_en_n_i (en_n[1])
  );

  function automatic logic [W-1:0] port_out(int d);
    return (d == 0) ? b_out : a_out;
  endfunction

  function automatic logic port_oe(int d);
    return (d == 0) ? b_oe : a_oe;
  endfunction

  function automatic logic [W-1:0] exp_out(int d);
    return pass[d] ? din[d] : m_hold[d];
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    for (int d = 0; d < 2; d++) begin
      if (pass[d]) begin
        m_hold[d] = din[d];
        m_tag[d]  = "R3";
      end else if (stb[d] && !m_prev[d]) begin
        if (!en_n[d]) begin
          m_hold[d] = din[d];
          m_tag[d]  = "R4";
        end else begin
          m_tag[d]  = "R6";
        end
      end else begin
        m_tag[d] = "R5";
      end
      m_prev[d] = stb[d];
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_dir(int d, string req);
    check(req, port_out(d), exp_out(d));
    check("R8", {{(W-1){1'b0}}, port_oe(d)}, {{(W-1){1'b0}}, !drv_n[d]});
  endtask

  task automatic settle_check_all();
    #1;
    for (int d = 0; d < 2; d++) begin
      check_dir(d, pass[d] ? "R2" : m_tag[d]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v0, v1, keep;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    for (int d = 0; d < 2; d++) begin
      din[d] = '0; drv_n[d] = 1'b1; pass[d] = 1'b0; stb[d] = 1'b0; en_n[d] = 1'b0;
      m_hold[d] = '0; m_prev[d] = 1'b0; m_tag[d] = "R5";
    end
    // R1: drivers stay off in reset even with drive enabled
    repeat (2) @(negedge clk);
    drv_n[0] = 1'b0;
    din[0] = 18'h2A5A5;
    repeat (2) @(negedge clk);
    #1;
    check("R1", {{(W-1){1'b0}}, b_oe}, '0);
    check("R1", {{(W-1){1'b0}}, a_oe}, '0);
    check("R1", b_out, '0);
    rst_n = 1'b1;
    #1;
    check("R1", {{(W-1){1'b0}}, b_oe}, '0);
    @(negedge clk);
    #1;
    check("R1", {{(W-1){1'b0}}, b_oe}, '0);
    repeat (3) tick();
    #1;
    check("R1", {{(W-1){1'b0}}, b_oe}, 18'd1);
    check("R1", b_out, '0);
    check("R1", a_out, '0);

    // R2: transparent in the same cycle
    tick();
    pass[0] = 1'b1; v0 = 18'h15555; din[0] = v0;
    #1; check("R2", b_out, v0);
    // R3: hold after pass falls
    tick();
    pass[0] = 1'b0; din[0] = 18'h0F0F0;
    #1; check("R3", b_out, v0);
    tick(); #1; check("R3", b_out, v0);

    // R4: strobe rise captures
    stb[0] = 1'b1; en_n[0] = 1'b0; v1 = 18'h3C3C3; din[0] = v1;
    #1; check("R4", b_out, v0);
    tick();
    din[0] = 18'h00001;
    #1; check("R4", b_out, v1);
    // R5: steady high then steady low
    tick(); din[0] = 18'h11111;
    #1; check("R5", b_out, v1);
    stb[0] = 1'b0; tick(); din[0] = 18'h22222;
    #1; check("R5", b_out, v1);
    tick(); #1; check("R5", b_out, v1);
    // R6: rise while strobe disabled
    en_n[0] = 1'b1; stb[0] = 1'b1; din[0] = 18'h33333;
    tick(); #1; check("R6", b_out, v1);
    tick(); #1; check("R6", b_out, v1);
    stb[0] = 1'b0; en_n[0] = 1'b0;
    tick();

    // R7: strobe activity while transparent
    pass[0] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      stb[0] = i[0]; en_n[0] = i[1]; din[0] = W'($urandom);
      #1; check("R7", b_out, din[0]);
      tick();
    end
    pass[0] = 1'b0; stb[0] = 1'b0; en_n[0] = 1'b0;
    tick();

    // R8: swap the driving direction
    drv_n[0] = 1'b1;
    #1; check("R8", {{(W-1){1'b0}}, b_oe}, '0);
    tick();
    drv_n[1] = 1'b0;
    #1; check("R8", {{(W-1){1'b0}}, a_oe}, 18'd1);
    check("R8", {{(W-1){1'b0}}, b_oe}, '0);

    // R9: churn B-to-A path, A-to-B output must stay put
    keep = b_out;
    for (int i = 0; i < 8; i++) begin
      tick();
      pass[1] = i[0]; stb[1] = i[1]; en_n[1] = i[2]; din[1] = W'($urandom);
      #1;
      check("R9", b_out, keep);
      check_dir(1, pass[1] ? "R2" : m_tag[1]);
    end

    // random mix, one driver at most
    for (int i = 0; i < 800; i++) begin
      tick();
      for (int d = 0; d < 2; d++) begin
        pass[d] = ($urandom_range(3) == 0);
        stb[d]  = $urandom_range(1);
        en_n[d] = ($urandom_range(3) == 0);
        din[d]  = W'($urandom);
      end
      case ($urandom_range(2))
        0: begin drv_n[0] = 1'b0; drv_n[1] = 1'b1; end
        1: begin drv_n[0] = 1'b1; drv_n[1] = 1'b0; end
        default: begin drv_n[0] = 1'b1; drv_n[1] = 1'b1; end
      endcase
      settle_check_all();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule